// File: doc/BRIEF.md
# NAND Command-Address Sequencer Bridge

This block sits between a simple memory-mapped request port and an 8-bit raw NAND bus. A write into the NAND window carries its whole command recipe in the bus address: the phase, a leading opcode, an optional trailing opcode and a count of address bytes. The block turns that recipe into a run of byte cycles, each with the right latch line raised and a write strobe pulsed. Address bytes come from the write data. Data-phase writes push their bytes straight onto the I/O lines. Reads pulse the read strobe and pack the returned bytes into a bus word.

A request may ask for up to seven address bytes, but one request sends no more than four. The remainder is held back and sent by the next command-phase request that names a nonzero count. That follow-on request does not send its own leading opcode. A trailing opcode waits until no address bytes are left over. A separate control window holds one status word, which mirrors the ready/busy lines of two attached devices.

The requester raises `bus_req` with stable fields and holds it until `bus_ready` pulses for one clock. Nothing is accepted while a run of byte cycles is in progress.

Top module: `nand_seq_bridge`

## Requirements
- R1: In the NAND window, address bit 19 = 1 selects the data phase and 0 the command phase. Bit 20 = 1 marks the trailing opcode as wanted. Bits 10:3 hold the leading opcode, bits 18:11 the trailing opcode and bits 23:21 the address-byte count. The count is treated as zero in the data phase.
- R2: A command-phase write with nothing left over sends, in this order: the leading opcode as a CLE cycle; min(count,4) ALE cycles carrying write-data bytes 0,1,2,3; and, if bit 20 is set and nothing is left over, the trailing opcode as a CLE cycle.
- R3: When the count is above four, the excess (count-4, at most 3) is kept. The next command-phase write with a nonzero count sends no leading opcode. It sends the kept number of ALE cycles from its own data bytes, starting at byte 0, in place of its own count, and the kept amount is then cleared.
- R4: No trailing opcode is sent by a write that leaves address bytes outstanding, even with bit 20 set.
- R5: A command-phase write with count 0 clears any kept amount, and so does any data-phase write. A command-phase write with count 0 sends the leading opcode only when nothing was kept. Reads leave the kept amount unchanged.
- R6: A data-phase write of `bus_size` bytes (1 to 4) sends the write-data bytes least significant first, with CLE and ALE low and `nand_io_oe` high. It is followed by the trailing opcode when bit 20 is set.
- R7: A NAND-window read of `bus_size` bytes (1 to 4) pulses `nand_re_n` once per byte and never drives the I/O lines. Byte k read is placed in bits 8k+7:8k of `bus_rdata`, and the unused upper bytes are zero.
- R8: A control-window read at word offset 0 (address bits above 1 all zero) returns `nand_rb[0]` in bit 5 and `nand_rb[1]` in bit 6, with all other bits zero. Any other control offset reads zero. Control-window writes cause no NAND cycle.
- R9: Each byte cycle lasts LOW_CLKS+HIGH_CLKS clocks. Its strobe (`nand_we_n` for writes, `nand_re_n` for reads) is low for the first LOW_CLKS clocks. CLE and ALE are never high together, and the two strobes are never low together.
- R10: `bus_ready` is a one-clock pulse given only after the last byte cycle of the request has ended. While no request is running, all strobes and latch lines are inactive.
- R11: A synchronous active-low reset clears the kept address count and leaves `nand_we_n`=`nand_re_n`=1, CLE=ALE=0, `nand_io_oe`=0 and `bus_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Request valid, held until bus_ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 1 = NAND window, 0 = control window |
| bus_addr | input | ADDR_W | Request address (carries the recipe in the NAND window) |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 3 | Byte count for NAND data transfers, 1 to 4 |
| bus_ready | output | 1 | One-clock completion pulse |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| nand_rb | input | 2 | Ready/busy of device 0 and 1 |
| nand_io_in | input | 8 | NAND I/O input bus |
| nand_io_out | output | 8 | NAND I/O output bus |
| nand_io_oe | output | 1 | Output enable for the I/O bus |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |

## Verification
A wrong kept address count is visible on the next command-phase write. The leading CLE byte appears or goes missing, the number of ALE bytes changes, or the trailing opcode moves, all within the byte cycles of that next request. A fault in the byte cursor or in the strobe counter shows in the same request as a reordered byte, a strobe of the wrong width, or a `bus_ready` pulse that arrives before the final strobe edge. A fault in read packing shows in `bus_rdata` on that request's ready pulse.

// File: rtl/nsb_pkg.sv
package nsb_pkg;

  localparam int MAX_OPS = 6;
  localparam int WORD_W  = 32;

  typedef enum logic [1:0] {
    OP_CMD = 2'd0,
    OP_ADR = 2'd1,
    OP_DWR = 2'd2,
    OP_DRD = 2'd3
  } op_kind_t;

  typedef struct packed {
    op_kind_t   kind;
    logic [7:0] dat;
  } nand_op_t;

  typedef struct packed {
    logic       data_ph;
    logic       tail_ok;
    logic [7:0] lead_op;
    logic [7:0] tail_op;
    logic [2:0] acnt;
  } win_fields_t;

  // address bytes wanted by this request after carry-over rules
  function automatic logic [2:0] addr_total(input logic [2:0] kept, input logic [2:0] cnt);
    if (cnt == 3'd0) return 3'd0;
    return (kept != 3'd0) ? kept : cnt;
  endfunction

  function automatic logic [2:0] burst_len(input logic [2:0] kept, input logic [2:0] cnt);
    logic [2:0] t;
    t = addr_total(kept, cnt);
    return (t > 3'd4) ? 3'd4 : t;
  endfunction

  function automatic logic [2:0] next_kept(input logic [2:0] kept, input logic [2:0] cnt);
    logic [2:0] t;
    t = addr_total(kept, cnt);
    return (t > 3'd4) ? (t - 3'd4) : 3'd0;
  endfunction

  function automatic logic [2:0] clamp_size(input logic [2:0] sz);
    if (sz == 3'd0) return 3'd1;
    return (sz > 3'd4) ? 3'd4 : sz;
  endfunction

  function automatic nand_op_t make_op(input op_kind_t k, input logic [7:0] d);
    nand_op_t o;
    o.kind = k;
    o.dat  = d;
    return o;
  endfunction

endpackage

// File: rtl/nsb_decode.sv
module nsb_decode
  import nsb_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output win_fields_t       fields,
  output logic              word0
);

  always_comb begin
    fields.data_ph = addr[19];
    fields.tail_ok = addr[20];
    fields.lead_op = addr[10:3];
    fields.tail_op = addr[18:11];
    fields.acnt    = addr[23:21];
  end

  assign word0 = (addr[ADDR_W-1:2] == '0);

endmodule

// File: rtl/nsb_planner.sv
module nsb_planner
  import nsb_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       is_read,
  input  win_fields_t                fields,
  input  logic [WORD_W-1:0]          wdata,
  input  logic [2:0]                 size,
  output nand_op_t [MAX_OPS-1:0]     ops,
  output logic [2:0]                 op_n,
  output logic [2:0]                 kept_q
);

  logic [2:0] eff_cnt;
  logic [2:0] kept_nxt;
  logic [2:0] nbytes;
  logic [2:0] nadr;

  always_comb begin
    logic [2:0] n;
    ops      = '0;
    n        = 3'd0;
    nbytes   = clamp_size(size);
    eff_cnt  = fields.data_ph ? 3'd0 : fields.acnt;
    kept_nxt = next_kept(kept_q, eff_cnt);
    nadr     = burst_len(kept_q, eff_cnt);
    if (is_read) begin
      for (int k = 0; k < 4; k++) begin
        if (3'(k) < nbytes) begin
          ops[n] = make_op(OP_DRD, 8'h00);
          n = n + 3'd1;
        end
      end
    end else begin
      if (fields.data_ph) begin
        for (int k = 0; k < 4; k++) begin
          if (3'(k) < nbytes) begin
            ops[n] = make_op(OP_DWR, wdata[8*k +: 8]);
            n = n + 3'd1;
          end
        end
      end else if (kept_q == 3'd0) begin
        ops[n] = make_op(OP_CMD, fields.lead_op);
        n = n + 3'd1;
      end
      for (int k = 0; k < 4; k++) begin
        if (3'(k) < nadr) begin
          ops[n] = make_op(OP_ADR, wdata[8*k +: 8]);
          n = n + 3'd1;
        end
      end
      if (fields.tail_ok && (kept_nxt == 3'd0)) begin
        ops[n] = make_op(OP_CMD, fields.tail_op);
        n = n + 3'd1;
      end
    end
    op_n = n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kept_q <= 3'd0;
    end else if (load && !is_read) begin
      kept_q <= kept_nxt;
    end
  end

endmodule

// File: rtl/nsb_strobe.sv
module nsb_strobe
  import nsb_pkg::*;
#(
  parameter int LOW_CLKS  = 1,
  parameter int HIGH_CLKS = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  nand_op_t [MAX_OPS-1:0] ops,
  input  logic [2:0]             op_n,
  input  logic [7:0]             io_in,
  output logic                   cle,
  output logic                   ale,
  output logic                   we_n,
  output logic                   re_n,
  output logic [7:0]             io_out,
  output logic                   io_oe,
  output logic                   busy,
  output logic                   done,
  output logic [WORD_W-1:0]      rdata
);

  localparam int TOT = LOW_CLKS + HIGH_CLKS;
  localparam int TW  = $clog2(TOT + 1);

  nand_op_t [MAX_OPS-1:0] ops_q;
  logic [2:0]             n_q;
  logic [2:0]             idx_q;
  logic [TW-1:0]          tick_q;
  logic                   act_q;
  logic [1:0]             rpos_q;
  nand_op_t               cur;
  logic                   low_ph;
  logic                   is_rd;
  logic                   last_tick;

  assign cur       = ops_q[idx_q];
  assign is_rd     = (cur.kind == OP_DRD);
  assign low_ph    = act_q && (tick_q < TW'(LOW_CLKS));
  assign last_tick = (tick_q == TW'(TOT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ops_q  <= '0;
      n_q    <= 3'd0;
      idx_q  <= 3'd0;
      tick_q <= '0;
      act_q  <= 1'b0;
      rpos_q <= 2'd0;
      done   <= 1'b0;
      rdata  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        ops_q  <= ops;
        n_q    <= op_n;
        idx_q  <= 3'd0;
        tick_q <= '0;
        act_q  <= (op_n != 3'd0);
        done   <= (op_n == 3'd0);
        rpos_q <= 2'd0;
        rdata  <= '0;
      end else if (act_q) begin
        if (is_rd && (tick_q == TW'(LOW_CLKS - 1))) begin
          rdata[8*rpos_q +: 8] <= io_in;
          rpos_q <= rpos_q + 2'd1;
        end
        if (last_tick) begin
          tick_q <= '0;
          if (idx_q == n_q - 3'd1) begin
            act_q <= 1'b0;
            done  <= 1'b1;
          end else begin
            idx_q <= idx_q + 3'd1;
          end
        end else begin
          tick_q <= tick_q + TW'(1);
        end
      end
    end
  end

  always_comb begin
    cle    = act_q && (cur.kind == OP_CMD);
    ale    = act_q && (cur.kind == OP_ADR);
    we_n   = !(low_ph && !is_rd);
    re_n   = !(low_ph && is_rd);
    io_oe  = act_q && !is_rd;
    io_out = (act_q && !is_rd) ? cur.dat : 8'h00;
  end

  assign busy = act_q;

endmodule

// File: rtl/nand_seq_bridge.sv
module nand_seq_bridge
  import nsb_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LOW_CLKS  = 1,
  parameter int HIGH_CLKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_win,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [2:0]        bus_size,
  output logic              bus_ready,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        nand_rb,
  input  logic [7:0]        nand_io_in,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_t;

  st_t                    st_q;
  win_fields_t            fields;
  logic                   word0;
  nand_op_t [MAX_OPS-1:0] plan_ops;
  logic [2:0]             plan_n;
  logic [2:0]             kept_cnt;
  logic                   seq_busy;
  logic                   seq_done;
  logic [WORD_W-1:0]      seq_rdata;
  logic [31:0]            rdata_q;

  // named events for the checker
  logic accept_nand;
  logic accept_ctrl;

  assign accept_nand = (st_q == ST_IDLE) && bus_req && bus_win;
  assign accept_ctrl = (st_q == ST_IDLE) && bus_req && !bus_win;

  nsb_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr   (bus_addr),
    .fields (fields),
    .word0  (word0)
  );

  nsb_planner u_plan (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept_nand),
    .is_read (!bus_we),
    .fields  (fields),
    .wdata   (bus_wdata),
    .size    (bus_size),
    .ops     (plan_ops),
    .op_n    (plan_n),
    .kept_q  (kept_cnt)
  );

  nsb_strobe #(.LOW_CLKS(LOW_CLKS), .HIGH_CLKS(HIGH_CLKS)) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept_nand),
    .ops    (plan_ops),
    .op_n   (plan_n),
    .io_in  (nand_io_in),
    .cle    (nand_cle),
    .ale    (nand_ale),
    .we_n   (nand_we_n),
    .re_n   (nand_re_n),
    .io_out (nand_io_out),
    .io_oe  (nand_io_oe),
    .busy   (seq_busy),
    .done   (seq_done),
    .rdata  (seq_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept_nand) begin
            st_q <= ST_RUN;
          end else if (accept_ctrl) begin
            rdata_q <= (!bus_we && word0) ? {25'd0, nand_rb[1], nand_rb[0], 5'd0} : 32'd0;
            st_q    <= ST_DONE;
          end
        end
        ST_RUN: begin
          if (seq_done) begin
            rdata_q <= seq_rdata;
            st_q    <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_ready = (st_q == ST_DONE);
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/nsb_checker.sv
module nsb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_ready,
  input logic       bus_we,
  input logic       accept_nand,
  input logic       seq_busy,
  input logic [2:0] kept_cnt,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic       nand_io_oe
);

  assert_latch_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  assert_ready_after_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> !seq_busy);

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe));

  assert_kept_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kept_cnt <= 3'd3);

  assert_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_nand && !bus_we) |=> $stable(kept_cnt));

  assert_no_drive_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);

  assert_reset_state_R11: assert property (@(posedge clk)
    !rst_n |=> (kept_cnt == 3'd0 && !bus_ready && nand_we_n && nand_re_n));

endmodule

bind nand_seq_bridge nsb_checker u_nsb_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_ready   (bus_ready),
  .bus_we      (bus_we),
  .accept_nand (accept_nand),
  .seq_busy    (seq_busy),
  .kept_cnt    (kept_cnt),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n),
  .nand_io_oe  (nand_io_oe)
);

// File: tb/nand_seq_bridge_tb.sv
module nand_seq_bridge_tb;

  localparam int LOWC = 1;
  localparam int HIGHC = 1;
  localparam logic [7:0] RD_STEP = 8'h1D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0, bus_win = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [2:0] bus_size = 3'd1;
  logic bus_ready;
  logic [31:0] bus_rdata;
  logic [1:0] nand_rb = 2'b00;
  logic [7:0] nand_io_in = 8'h41;
  logic [7:0] nand_io_out;
  logic nand_io_oe, nand_cle, nand_ale, nand_we_n, nand_re_n;

  always #5 clk = ~clk;

  nand_seq_bridge #(.ADDR_W(24), .LOW_CLKS(LOWC), .HIGH_CLKS(HIGHC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_win(bus_win),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .nand_rb(nand_rb),
    .nand_io_in(nand_io_in), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n));

  int n_cmp = 0;
  int n_bad = 0;

  // kind codes in the log: 1 = CLE byte, 2 = ALE byte, 3 = plain data byte
  int         log_kind [64];
  logic [7:0] log_byte [64];
  int         log_n = 0;
  int         rd_pulses = 0;
  int         exp_kind [16];
  logic [7:0] exp_byte [16];
  int         exp_n = 0;
  logic [2:0] m_kept = 3'd0;

  logic prev_we = 1'b1, prev_re = 1'b1;
  int   low_run = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin monitor
  always @(negedge clk) begin
    if (!nand_we_n || !nand_re_n) low_run++;
    if (prev_we == 1'b0 && nand_we_n == 1'b1) begin
      if (log_n < 64) begin
        log_kind[log_n] = nand_cle ? 1 : (nand_ale ? 2 : 3);
        log_byte[log_n] = nand_io_out;
        log_n++;
      end
      check(low_run == LOWC, "R9 we_n low width", low_run, LOWC);
      low_run = 0;
    end
    if (prev_re == 1'b0 && nand_re_n == 1'b1) begin
      rd_pulses++;
      nand_io_in = nand_io_in + RD_STEP;
      check(low_run == LOWC, "R9 re_n low width", low_run, LOWC);
      low_run = 0;
    end
    if (nand_cle && nand_ale) check(0, "R9 cle and ale together", 1, 0);
    prev_we = nand_we_n;
    prev_re = nand_re_n;
  end

  int cyc = 0;
  bit wd_hit = 0;
  always @(posedge clk) cyc++;

  task automatic push_exp(input int k, input logic [7:0] b);
    exp_kind[exp_n] = k;
    exp_byte[exp_n] = b;
    exp_n++;
  endtask

  // expected NAND byte stream of a write into the NAND window
  task automatic model_write(input logic [23:0] a, input logic [31:0] d, input logic [2:0] sz);
    logic [2:0] want, now_cnt;
    exp_n = 0;
    if (a[19]) begin
      for (int k = 0; k < sz; k++) push_exp(3, d[8*k +: 8]);
      want = 3'd0;
    end else begin
      if (m_kept == 3'd0) push_exp(1, a[10:3]);
      if (a[23:21] == 3'd0) want = 3'd0;
      else if (m_kept != 3'd0) want = m_kept;
      else want = a[23:21];
    end
    now_cnt = (want >= 3'd4) ? 3'd4 : want;
    m_kept = want - now_cnt;
    for (int k = 0; k < now_cnt; k++) push_exp(2, d[8*k +: 8]);
    if (a[20] && m_kept == 3'd0) push_exp(1, a[18:11]);
  endtask

  task automatic bus_op(input bit win, input bit we, input logic [23:0] a,
                        input logic [31:0] d, input logic [2:0] sz, output logic [31:0] rd);
    int wait_c;
    @(negedge clk);
    log_n = 0;
    rd_pulses = 0;
    bus_req = 1'b1; bus_we = we; bus_win = win; bus_addr = a; bus_wdata = d; bus_size = sz;
    wait_c = 0;
    @(negedge clk);
    while (!bus_ready && wait_c < 300) begin
      @(negedge clk);
      wait_c++;
    end
    if (!bus_ready) begin
      wd_hit = 1;
      check(0, "R10 watchdog ready never seen", 0, 1);
    end
    rd = bus_rdata;
    bus_req = 1'b0;
    @(negedge clk);
    check(!bus_ready, "R10 ready lasts one clock", bus_ready, 0);
    check(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe,
          "R10 pins quiet after ready", {nand_we_n, nand_re_n, nand_cle, nand_ale}, 4'b1100);
    repeat (2) @(negedge clk);
  endtask

  task automatic nand_write(input logic [23:0] a, input logic [31:0] d, input logic [2:0] sz, input string req);
    logic [31:0] rd;
    model_write(a, d, sz);
    bus_op(1'b1, 1'b1, a, d, sz, rd);
    check(log_n == exp_n, req, log_n, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      if (i < log_n)
        check(log_kind[i] == exp_kind[i] && log_byte[i] == exp_byte[i], req,
              {log_kind[i][7:0], log_byte[i]}, {exp_kind[i][7:0], exp_byte[i]});
    end
  endtask

  task automatic nand_read(input logic [2:0] sz);
    logic [31:0] rd, want;
    logic [7:0] base;
    base = nand_io_in;
    want = '0;
    for (int k = 0; k < sz; k++) want[8*k +: 8] = base + RD_STEP * 8'(k);
    bus_op(1'b1, 1'b0, 24'h080000, 32'h0, sz, rd);
    check(rd == want, "R7 read packing", rd, want);
    check(rd_pulses == int'(sz) && log_n == 0, "R7 read strobes", rd_pulses, sz);
  endtask

  function automatic logic [23:0] cmd_addr(input logic [2:0] cnt, input bit tail,
                                           input logic [7:0] lead, input logic [7:0] tl);
    return {cnt, tail, 1'b0, tl, lead, 3'b000};
  endfunction

  initial begin : watchdog
    wait (cyc > 150000);
    wd_hit = 1;
  end

  initial begin : main
    logic [31:0] rd;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_io_oe && !bus_ready,
          "R11 reset pins", {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe, bus_ready}, 6'b110000);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 plain command with 3 address bytes and tail
    nand_write(cmd_addr(3'd3, 1'b1, 8'h80, 8'h10), 32'hCAFE_BABE, 3'd1, "R2 cmd+addr+tail");
    // R3 R4 seven address bytes split over two writes
    nand_write(cmd_addr(3'd7, 1'b1, 8'h00, 8'h30), 32'h4433_2211, 3'd1, "R4 tail withheld");
    nand_write(cmd_addr(3'd1, 1'b1, 8'h55, 8'h66), 32'h0099_8877, 3'd1, "R3 carry-over bytes");
    // R5 zero count clears kept amount, lead suppressed
    nand_write(cmd_addr(3'd6, 1'b0, 8'h11, 8'h22), 32'hA1B2_C3D4, 3'd1, "R3 six bytes");
    nand_write(cmd_addr(3'd0, 1'b1, 8'h77, 8'hE0), 32'h0, 3'd1, "R5 zero count clears");
    nand_write(cmd_addr(3'd2, 1'b0, 8'h05, 8'h00), 32'h0000_ABCD, 3'd1, "R5 lead back after clear");
    // R5 data write clears kept amount
    nand_write(cmd_addr(3'd5, 1'b0, 8'h60, 8'h00), 32'h0102_0304, 3'd1, "R3 five bytes");
    nand_write(24'h180000 | (24'h5A << 11), 32'hDEAD_BEEF, 3'd2, "R6 data with tail");
    nand_write(cmd_addr(3'd1, 1'b0, 8'h70, 8'h00), 32'h0000_00EE, 3'd1, "R5 after data write");
    // R6 data widths
    for (int s = 1; s <= 4; s++) nand_write(24'h080000, 32'h8765_4321, 3'(s), "R6 data bytes");
    // R7 reads, and reads leave kept amount alone
    nand_write(cmd_addr(3'd6, 1'b0, 8'h31, 8'h00), 32'h1111_2222, 3'd1, "R3 before read");
    for (int s = 1; s <= 4; s++) nand_read(3'(s));
    nand_write(cmd_addr(3'd4, 1'b0, 8'h32, 8'h00), 32'h3333_4444, 3'd1, "R5 read kept amount");
    // R8 status
    for (int v = 0; v < 4; v++) begin
      nand_rb = 2'(v);
      bus_op(1'b0, 1'b0, 24'h000000, 32'h0, 3'd4, rd);
      check(rd == {25'd0, nand_rb[1], nand_rb[0], 5'd0}, "R8 status bits", rd, {25'd0, nand_rb, 5'd0});
    end
    nand_rb = 2'b11;
    bus_op(1'b0, 1'b0, 24'h000004, 32'h0, 3'd4, rd);
    check(rd == 32'd0, "R8 other offset zero", rd, 0);
    bus_op(1'b0, 1'b1, 24'h000000, 32'hFFFF_FFFF, 3'd4, rd);
    check(log_n == 0 && rd_pulses == 0, "R8 control write no cycles", log_n, 0);
    // R11 reset clears kept amount
    nand_write(cmd_addr(3'd7, 1'b0, 8'h44, 8'h00), 32'h5555_6666, 3'd1, "R3 before reset");
    @(negedge clk); rst_n = 1'b0; m_kept = 3'd0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    nand_write(cmd_addr(3'd1, 1'b0, 8'h9A, 8'h00), 32'h0000_0077, 3'd1, "R11 reset clears kept");

    // random mix
    for (int t = 0; t < 200 && !wd_hit; t++) begin
      int pick;
      logic [23:0] a;
      logic [31:0] d;
      pick = $urandom_range(0, 9);
      d = $urandom;
      a = 24'($urandom);
      if (pick < 6) begin
        a[19] = 1'b0;
        nand_write(a, d, 3'd1, "R2 random command");
      end else if (pick < 8) begin
        a[19] = 1'b1;
        nand_write(a, d, 3'($urandom_range(1, 4)), "R6 random data");
      end else begin
        nand_read(3'($urandom_range(1, 4)));
      end
    end

    if (wd_hit) check(0, "R10 watchdog expired", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : hang_guard
    wait (cyc > 190000);
    n_cmp++;
    n_bad++;
    $display("FAIL R10 watchdog run hung actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule